// File: doc/BRIEF.md
# Run-time selectable forward/inverse transform wrapper

This block sits around a forward-only FFT datapath so one transform engine can produce either the forward or the inverse transform. Each clock carries a vector of complex samples, a valid flag and a mode bit. In forward mode the samples pass through untouched. In inverse mode the real and imaginary parts of every lane are exchanged before the samples reach the engine. The engine's results are exchanged again on the way out. Exchanging the parts on both sides gives the inverse transform without conjugation and without any division by the frame length.

The FFT engine's input and output are brought out as ports, so the engine is an external fixed-latency pipeline. The wrapper tracks frame boundaries by counting valid input cycles. It latches the mode on the first valid cycle of each frame. A one-bit delay line, as deep as the engine latency plus the front register, carries that mode so the back-end exchange acts on the matching frame. Lanes keep their positions and the engine's bit-reversed ordering is left as it is.

Top module: `fft_mode_wrap`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, core_in_valid and out_valid are 0.
- R2: In forward mode (mode bit 1), core_in_re and core_in_im equal in_re and in_im of the previous cycle, bit for bit, in every lane.
- R3: In inverse mode (mode bit 0), each lane is exchanged one cycle later: core_in_re lane k equals in_im lane k and core_in_im lane k equals in_re lane k. Lane k occupies bits [k*DW +: DW].
- R4: core_in_valid equals in_valid delayed by one cycle.
- R5: out_valid equals core_out_valid delayed by one cycle. For a forward frame out_re/out_im equal core_out_re/core_out_im. For an inverse frame they are exchanged per lane. There is no lane reordering and no scaling.
- R6: A frame is FRAME_LEN/LANES valid input cycles (64 by default). The first valid cycle after reset starts a frame, and cycles with in_valid low do not advance the frame position.
- R7: The mode bit is taken on the first valid cycle of a frame and used for every cycle of that frame. Changes to in_fwd on later cycles of the frame have no effect.
- R8: The engine is a pipeline of FFT_LAT cycles. The output-side exchange uses the mode of the frame whose samples are on core_out that cycle, so the end-to-end latency is FFT_LAT+2 cycles.
- R9: A reset in the middle of a frame discards the partial frame. The next valid cycle starts a new frame and takes a new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input samples valid |
| in_fwd | input | 1 | Mode: 1 forward, 0 inverse (taken at frame start) |
| in_re | input | LANES*DW | Real parts, lane k at [k*DW +: DW] |
| in_im | input | LANES*DW | Imaginary parts, same lane layout |
| core_in_valid | output | 1 | Valid toward the FFT engine |
| core_in_re | output | LANES*DW | Real parts toward the engine |
| core_in_im | output | LANES*DW | Imaginary parts toward the engine |
| core_out_valid | input | 1 | Valid from the FFT engine |
| core_out_re | input | LANES*DW | Real parts from the engine |
| core_out_im | input | LANES*DW | Imaginary parts from the engine |
| out_valid | output | 1 | Result valid |
| out_re | output | LANES*DW | Result real parts |
| out_im | output | LANES*DW | Result imaginary parts |

## Verification
On every cycle the assertions check the one-cycle valid alignment on both sides and the per-lane pass-through or exchange at the front and back registers under the mode in force. They also check that the front-side mode cannot change except on a frame's first valid cycle. Some behaviour only the bench scenarios can show, because the bench's engine model returns results after a fixed delay and the output must then reflect the frame that entered earlier. These are: frame counting across idle gaps, the pairing of a frame's mode with its results FFT_LAT cycles later, and the restart of frame counting after a reset in mid-frame.

// File: rtl/fft_mode_pkg.sv
package fft_mode_pkg;

  typedef enum logic {
    XF_INVERSE = 1'b0,
    XF_FORWARD = 1'b1
  } xform_e;

  // Exchange is needed whenever the mode bit selects the inverse transform.
  function automatic logic needs_exchange(input logic fwd_bit);
    return fwd_bit == XF_INVERSE;
  endfunction

  // Number of vector beats that make up one frame.
  function automatic int unsigned beats_per_frame(input int unsigned frame_len,
                                                  input int unsigned lanes);
    return frame_len / lanes;
  endfunction

endpackage

// File: rtl/fft_frame_mode.sv
module fft_frame_mode #(
  parameter int unsigned FRAME_BEATS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_fwd,
  output logic frame_first,
  output logic eff_fwd
);
  import fft_mode_pkg::*;

  localparam int unsigned CW = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1;
  localparam logic [CW-1:0] LAST_BEAT = CW'(FRAME_BEATS - 1);

  logic [CW-1:0] beat_q;
  logic          held_fwd_q;

  assign frame_first = (beat_q == '0);
  // First beat uses the live mode bit; the rest of the frame uses the latched one.
  assign eff_fwd = frame_first ? in_fwd : held_fwd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q     <= '0;
      held_fwd_q <= XF_FORWARD;
    end else if (in_valid) begin
      if (beat_q == LAST_BEAT) beat_q <= '0;
      else                     beat_q <= beat_q + 1'b1;
      if (frame_first) held_fwd_q <= in_fwd;
    end
  end

endmodule

// File: rtl/fft_lane_xchg.sv
module fft_lane_xchg #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic                exch_i,
  input  logic [LANES*DW-1:0] re_i,
  input  logic [LANES*DW-1:0] im_i,
  output logic                vld_o,
  output logic [LANES*DW-1:0] re_o,
  output logic [LANES*DW-1:0] im_o
);
  localparam int unsigned W = LANES * DW;

  // Returns {new_re, new_im} for one lane.
  function automatic logic [2*DW-1:0] lane_map(input logic [DW-1:0] re,
                                               input logic [DW-1:0] im,
                                               input logic       exch);
    return exch ? {im, re} : {re, im};
  endfunction

  logic [W-1:0] re_d, im_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [2*DW-1:0] pair;
    assign pair             = lane_map(re_i[g*DW +: DW], im_i[g*DW +: DW], exch_i);
    assign re_d[g*DW +: DW] = pair[2*DW-1:DW];
    assign im_d[g*DW +: DW] = pair[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      re_o  <= '0;
      im_o  <= '0;
    end else begin
      vld_o <= vld_i;
      re_o  <= re_d;
      im_o  <= im_d;
    end
  end

endmodule

// File: rtl/fft_mode_delay.sv
module fft_mode_delay #(
  parameter int unsigned DEPTH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic d_o
);
  logic [DEPTH-1:0] sr_q;

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= {sr_q[DEPTH-2:0], d_i};
    end
  end

  assign d_o = sr_q[DEPTH-1];

endmodule

// File: rtl/fft_mode_wrap.sv
module fft_mode_wrap
  import fft_mode_pkg::*;
#(
  parameter int unsigned LANES     = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned FRAME_LEN = 512,
  parameter int unsigned FFT_LAT   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_fwd,
  input  logic [LANES*DW-1:0] in_re,
  input  logic [LANES*DW-1:0] in_im,
  output logic                core_in_valid,
  output logic [LANES*DW-1:0] core_in_re,
  output logic [LANES*DW-1:0] core_in_im,
  input  logic                core_out_valid,
  input  logic [LANES*DW-1:0] core_out_re,
  input  logic [LANES*DW-1:0] core_out_im,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_re,
  output logic [LANES*DW-1:0] out_im
);
  localparam int unsigned FRAME_BEATS = beats_per_frame(FRAME_LEN, LANES);
  // Front register plus engine latency: aligns the mode with core_out.
  localparam int unsigned MODE_DEPTH  = FFT_LAT + 1;

  logic frame_first;  // current input cycle is a frame's first beat
  logic eff_fwd;      // mode in force for the current input cycle
  logic back_fwd;     // mode of the frame now on core_out
  logic front_exch;
  logic back_exch;

  assign front_exch = needs_exchange(eff_fwd);
  assign back_exch  = needs_exchange(back_fwd);

  fft_frame_mode #(.FRAME_BEATS(FRAME_BEATS)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_fwd      (in_fwd),
    .frame_first (frame_first),
    .eff_fwd     (eff_fwd)
  );

  fft_lane_xchg #(.LANES(LANES), .DW(DW)) u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_valid),
    .exch_i (front_exch),
    .re_i   (in_re),
    .im_i   (in_im),
    .vld_o  (core_in_valid),
    .re_o   (core_in_re),
    .im_o   (core_in_im)
  );

  fft_mode_delay #(.DEPTH(MODE_DEPTH)) u_mdly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (eff_fwd),
    .d_o   (back_fwd)
  );

  fft_lane_xchg #(.LANES(LANES), .DW(DW)) u_back (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (core_out_valid),
    .exch_i (back_exch),
    .re_i   (core_out_re),
    .im_i   (core_out_im),
    .vld_o  (out_valid),
    .re_o   (out_re),
    .im_o   (out_im)
  );

endmodule

// File: rtl/fft_mode_wrap_chk.sv
module fft_mode_wrap_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*DW-1:0] in_re,
  input logic [LANES*DW-1:0] in_im,
  input logic                core_in_valid,
  input logic [LANES*DW-1:0] core_in_re,
  input logic [LANES*DW-1:0] core_in_im,
  input logic                core_out_valid,
  input logic [LANES*DW-1:0] core_out_re,
  input logic [LANES*DW-1:0] core_out_im,
  input logic                out_valid,
  input logic [LANES*DW-1:0] out_re,
  input logic [LANES*DW-1:0] out_im,
  input logic                frame_first,
  input logic                eff_fwd,
  input logic                back_fwd
);
  logic warm;      // one clock seen since reset release
  logic last_eff;  // mode used on the previous valid input cycle

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm     <= 1'b0;
      last_eff <= 1'b1;
    end else begin
      warm <= 1'b1;
      if (in_valid) last_eff <= eff_fwd;
    end
  end

  assert_in_valid_R4: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    core_in_valid == $past(in_valid));

  assert_in_pass_R2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ($past(in_valid) && $past(eff_fwd)) |->
      (core_in_re == $past(in_re) && core_in_im == $past(in_im)));

  assert_in_swap_R3: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ($past(in_valid) && !$past(eff_fwd)) |->
      (core_in_re == $past(in_im) && core_in_im == $past(in_re)));

  assert_out_valid_R5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    out_valid == $past(core_out_valid));

  assert_out_pass_R5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ($past(core_out_valid) && $past(back_fwd)) |->
      (out_re == $past(core_out_re) && out_im == $past(core_out_im)));

  assert_out_swap_R5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ($past(core_out_valid) && !$past(back_fwd)) |->
      (out_re == $past(core_out_im) && out_im == $past(core_out_re)));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (in_valid && !frame_first) |-> (eff_fwd == last_eff));

endmodule

bind fft_mode_wrap fft_mode_wrap_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_re          (in_re),
  .in_im          (in_im),
  .core_in_valid  (core_in_valid),
  .core_in_re     (core_in_re),
  .core_in_im     (core_in_im),
  .core_out_valid (core_out_valid),
  .core_out_re    (core_out_re),
  .core_out_im    (core_out_im),
  .out_valid      (out_valid),
  .out_re         (out_re),
  .out_im         (out_im),
  .frame_first    (frame_first),
  .eff_fwd        (eff_fwd),
  .back_fwd       (back_fwd)
);

// File: tb/fft_mode_wrap_tb.sv
module fft_mode_wrap_tb;
  localparam int LANES     = 8;
  localparam int DW        = 16;
  localparam int FRAME_LEN = 512;
  localparam int FFT_LAT   = 8;
  localparam int W         = LANES * DW;
  localparam int FCYC      = FRAME_LEN / LANES;
  localparam int RING      = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic         rst_n;
  logic         in_valid, in_fwd;
  logic [W-1:0] in_re, in_im;
  logic         core_in_valid, core_out_valid, out_valid;
  logic [W-1:0] core_in_re, core_in_im, core_out_re, core_out_im, out_re, out_im;

  fft_mode_wrap #(.LANES(LANES), .DW(DW), .FRAME_LEN(FRAME_LEN), .FFT_LAT(FFT_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fwd(in_fwd),
    .in_re(in_re), .in_im(in_im),
    .core_in_valid(core_in_valid), .core_in_re(core_in_re), .core_in_im(core_in_im),
    .core_out_valid(core_out_valid), .core_out_re(core_out_re), .core_out_im(core_out_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

  // Engine stand-in: a distinct per-lane mapping then a fixed delay.
  function automatic logic [W-1:0] eng_re(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*DW +: DW] = v[k*DW +: DW] + DW'(16'h0123) + DW'(k);
    return r;
  endfunction
  function automatic logic [W-1:0] eng_im(input logic [W-1:0] v);
    return ~v;
  endfunction

  logic         eq_v[FFT_LAT];
  logic [W-1:0] eq_r[FFT_LAT], eq_i[FFT_LAT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FFT_LAT; i++) begin eq_v[i] <= 1'b0; eq_r[i] <= '0; eq_i[i] <= '0; end
    end else begin
      eq_v[0] <= core_in_valid;
      eq_r[0] <= eng_re(core_in_re);
      eq_i[0] <= eng_im(core_in_im);
      for (int i = 1; i < FFT_LAT; i++) begin
        eq_v[i] <= eq_v[i-1]; eq_r[i] <= eq_r[i-1]; eq_i[i] <= eq_i[i-1];
      end
    end
  end
  assign core_out_valid = eq_v[FFT_LAT-1];
  assign core_out_re    = eq_r[FFT_LAT-1];
  assign core_out_im    = eq_i[FFT_LAT-1];

  // Expectations indexed by the clock edge that samples the input.
  logic         e_v[RING], e_m[RING];
  logic [W-1:0] e_cr[RING], e_ci[RING], e_or[RING], e_oi[RING];
  int  ecnt = 0;
  int  nchk = 0, nfail = 0;
  int  bcnt;
  logic bmode;
  logic chk_en = 1'b0;
  string phase = "R1";

  always @(posedge clk) ecnt = ecnt + 1;

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] r;
    for (int k = 0; k < W; k += 32) r[k +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  task automatic clear_ring();
    for (int i = 0; i < RING; i++) begin
      e_v[i] = 0; e_m[i] = 1; e_cr[i] = '0; e_ci[i] = '0; e_or[i] = '0; e_oi[i] = '0;
    end
  endtask

  // One cycle of stimulus with expected values from the requirements.
  task automatic drive(input logic v, input logic fwd, input logic [W-1:0] re, input logic [W-1:0] im);
    int s;
    logic m;
    @(posedge clk); #1;
    in_valid = v; in_fwd = fwd; in_re = re; in_im = im;
    s = (ecnt + 1) % RING;
    m = (v && bcnt == 0) ? fwd : bmode;
    e_v[s] = v; e_m[s] = m;
    if (m) begin
      e_cr[s] = re; e_ci[s] = im;
      e_or[s] = eng_re(re); e_oi[s] = eng_im(im);
    end else begin
      e_cr[s] = im; e_ci[s] = re;
      e_or[s] = eng_im(re); e_oi[s] = eng_re(im);
    end
    if (v) begin
      if (bcnt == 0) bmode = fwd;
      bcnt = (bcnt + 1) % FCYC;
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      int s, o;
      s = ecnt % RING;
      o = (((ecnt - FFT_LAT - 1) % RING) + RING) % RING;
      chk("R4 core_in_valid", W'(core_in_valid), W'(e_v[s]));
      if (e_v[s]) begin
        chk(e_m[s] ? "R2 core_in_re" : "R3 core_in_re", core_in_re, e_cr[s]);
        chk(e_m[s] ? "R2 core_in_im" : "R3 core_in_im", core_in_im, e_ci[s]);
      end
      chk("R5 R8 out_valid", W'(out_valid), W'(e_v[o]));
      if (e_v[o]) begin
        chk("R5 R8 out_re", out_re, e_or[o]);
        chk("R5 R8 out_im", out_im, e_oi[o]);
      end
    end
  end

  task automatic do_reset(input int n);
    rst_n = 1'b0; chk_en = 1'b0;
    bcnt = 0; bmode = 1'b1;
    clear_ring();
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 1'b1, '0, '0);
      @(negedge clk);
      chk("R1 core_in_valid in reset", W'(core_in_valid), '0);
      chk("R1 out_valid in reset", W'(out_valid), '0);
    end
    rst_n = 1'b1; chk_en = 1'b1;  // released mid-cycle
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    in_valid = 0; in_fwd = 1; in_re = '0; in_im = '0; rst_n = 0;
    bcnt = 0; bmode = 1;
    clear_ring();
    phase = "R1";
    do_reset(4);

    // R7: forward frame, mode bit toggling after the first beat.
    phase = "R7";
    for (int i = 0; i < FCYC; i++) drive(1'b1, (i == 0) ? 1'b1 : logic'($urandom % 2), rnd_vec(), rnd_vec());
    // R7: inverse frame, mode bit forced high after the first beat.
    for (int i = 0; i < FCYC; i++) drive(1'b1, (i == 0) ? 1'b0 : 1'b1, rnd_vec(), rnd_vec());

    // R6: idle gaps inside a frame do not advance the frame position.
    phase = "R6";
    for (int i = 0; i < FCYC * 3 / 2; i++) drive((i % 3) != 2, logic'($urandom % 2), rnd_vec(), rnd_vec());
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, rnd_vec(), rnd_vec());

    // R8: random traffic; each frame's mode must meet its results later.
    phase = "R8";
    for (int i = 0; i < 700; i++) drive(($urandom % 4) != 0, logic'($urandom % 2), rnd_vec(), rnd_vec());

    // R9: reset in the middle of a forward frame, then an inverse frame.
    phase = "R9";
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, rnd_vec(), rnd_vec());
    do_reset(3);
    for (int i = 0; i < FCYC; i++) drive(1'b1, (i == 0) ? 1'b0 : 1'b1, rnd_vec(), rnd_vec());

    // R5: extreme codes pass bit-exact in both modes, no scaling.
    phase = "R5";
    for (int i = 0; i < FCYC; i++) drive(1'b1, 1'b0, {LANES{16'h8000}}, {LANES{16'h7FFF}});
    for (int i = 0; i < FCYC; i++) drive(1'b1, 1'b1, {LANES{16'hFFFF}}, {LANES{16'h0001}});

    for (int i = 0; i < FFT_LAT + 6; i++) drive(1'b0, 1'b1, '0, '0);
    @(negedge clk);
    summary();
    $finish;
  end

endmodule